// File: doc/BRIEF.md
# Video Back-Porch Digital Clamp

This block sits after the video converter in a composite video capture path. It receives 8-bit samples, one per cycle in which `smp_vld` is high, together with a level that marks the horizontal sync interval. On every line it measures the blanking level by averaging a short window of samples on the back porch. The window opens a programmable number of samples after the sync marker. Every sample is then shifted so that the measured blanking lands on a fixed code chosen by the video standard: 0x3C for NTSC and 0x40 for PAL.

During sync, samples that the shift would place below blanking are replaced by a programmable sync-tip code. The measured porch level is always available as an 8-bit status value. When the clamp is switched off, samples pass through unchanged. The porch measurement keeps running in either case, so the clamp can be switched on again without waiting for a new line.

Top module: `bpc_clamp`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_vld` is 0 and `out_data` is 0x00. Until the first measurement completes, `blank_lvl` shows the blanking target of the selected standard: 0x3C when `pal_sel`=0 and 0x40 when `pal_sel`=1.
- R2: With `clamp_en`=1, each valid sample produces `out_data` = sample − porch + target in the cycle after it is accepted, and `out_vld` is 1 in that cycle. The target is 0x3C for `pal_sel`=0 and 0x40 for `pal_sel`=1.
- R3: The shifted result saturates: results below 0x00 give 0x00, and results above 0xFF give 0xFF.
- R4: With `clamp_en`=1 and `hs_mark`=1, a shifted result below the target is replaced by the sync-tip code. The code is `tip_val` for NTSC and `tip_val`+4 for PAL, so the value 3 gives 0x03 and 0x07. A result at or above the target is not replaced.
- R5: With `clamp_en`=0, `out_data` equals the accepted sample, with no shift and no sync-tip replacement.
- R6: Sample index 0 is the first valid sample with `hs_mark`=1 after a valid sample with `hs_mark`=0, or the first such sample after reset. Later valid samples count up from there. The porch is the floor average of the 16 valid samples at indexes `porch_ofs` to `porch_ofs`+15. It takes effect on `blank_lvl` and on samples accepted after the 16th of these.
- R7: The porch is measured once per line. Valid samples outside the window do not change `blank_lvl`.
- R8: Before the first measurement completes, the porch equals the target, so clamped samples come out unshifted.
- R9: After a measurement, `blank_lvl` reports the measured porch regardless of `pal_sel`.
- R10: A cycle with `smp_vld`=0 gives `out_vld`=0 in the next cycle. It leaves `out_data` and the line sample count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample on `smp_data` is valid this cycle |
| smp_data | input | 8 | Converter sample |
| hs_mark | input | 1 | High during the horizontal sync interval |
| pal_sel | input | 1 | 0 selects NTSC levels, 1 selects PAL levels |
| clamp_en | input | 1 | 1 enables the shift and sync-tip replacement |
| tip_val | input | 4 | Programmed sync-tip value |
| porch_ofs | input | 8 | Samples from the line start to the first sample of the porch window |
| out_data | output | 8 | Clamped or passed-through sample |
| out_vld | output | 1 | `out_data` carries a new sample this cycle |
| blank_lvl | output | 8 | Porch level currently applied |

## Verification
The hardest conditions to reach are the two saturation limits. Each needs a measured porch well away from the target: one far above it for the low limit, and one far below it for the high limit. Each limit also needs samples that push the sum past 8 bits in the right direction. The stimulus first drives a full sync-and-porch line whose window averages to 0x50, with one odd sample to exercise flooring. With that porch it walks the vector table in both standards. It then drives a second line in PAL whose porch settles at 0x20, which lifts bright samples into the upper limit. Moving the window offset far past the samples being driven keeps these lines from remeasuring the porch.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  localparam int unsigned PIX_W       = 8;
  localparam int unsigned TIP_W       = 4;
  localparam logic [7:0]  NTSC_BLANK  = 8'h3C;
  localparam logic [7:0]  PAL_BLANK   = 8'h40;
  localparam logic [4:0]  PAL_TIP_ADD = 5'd4;

  // Blanking code the clamp drives the porch to.
  function automatic logic [7:0] blank_target(input logic pal);
    return pal ? PAL_BLANK : NTSC_BLANK;
  endfunction

  // Output code used for sync samples that fall below blanking.
  function automatic logic [4:0] sync_tip_code(input logic pal, input logic [3:0] tip);
    return {1'b0, tip} + (pal ? PAL_TIP_ADD : 5'd0);
  endfunction

endpackage

// File: rtl/bpc_line_timer.sv
module bpc_line_timer #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned OFS_W    = 8,
  parameter int unsigned AVG_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic             hs_mark,
  input  logic [OFS_W-1:0] porch_ofs,
  output logic             win_hit,
  output logic             win_first,
  output logic             win_last
);

  localparam int unsigned   AVG_N   = 1 << AVG_LOG2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             hs_prev_q, hs_prev_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] idx, win_lo, win_hi;
  logic             line_start;

  // Index of the current sample within the line.
  always_comb begin
    line_start = smp_vld && hs_mark && !hs_prev_q;
    idx        = line_start ? '0 : cnt_q;
    win_lo     = {{(CNT_W-OFS_W){1'b0}}, porch_ofs};
    win_hi     = win_lo + CNT_W'(AVG_N - 1);
    win_hit    = smp_vld && (idx >= win_lo) && (idx <= win_hi);
    win_first  = win_hit && (idx == win_lo);
    win_last   = win_hit && (idx == win_hi);
  end

  always_comb begin
    cnt_d     = cnt_q;
    hs_prev_d = hs_prev_q;
    if (smp_vld) begin
      hs_prev_d = hs_mark;
      cnt_d     = (idx == CNT_MAX) ? idx : idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_prev_q <= 1'b0;
      cnt_q     <= CNT_MAX;
    end else begin
      hs_prev_q <= hs_prev_d;
      cnt_q     <= cnt_d;
    end
  end

  // R10: an idle cycle does not advance the line count.
  AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(cnt_q)); // R10

  // R6: the window always opens on its first sample before it closes.
  AST_WIN_SINGLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_first && win_last) == 1'b0); // R6

endmodule

// File: rtl/bpc_porch_avg.sv
module bpc_porch_avg #(
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned AVG_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] smp_data,
  input  logic             win_hit,
  input  logic             win_first,
  input  logic             win_last,
  output logic [PIX_W-1:0] meas,
  output logic             meas_ok
);

  localparam int unsigned ACC_W = PIX_W + AVG_LOG2;

  logic [ACC_W-1:0] acc_q, acc_d, sum_now;
  logic [PIX_W-1:0] meas_q, meas_d;
  logic             ok_q, ok_d;

  always_comb begin
    sum_now = (win_first ? '0 : acc_q) + {{AVG_LOG2{1'b0}}, smp_data};
    acc_d   = acc_q;
    meas_d  = meas_q;
    ok_d    = ok_q;
    if (win_hit) begin
      acc_d = sum_now;
    end
    if (win_last) begin
      meas_d = sum_now[ACC_W-1:AVG_LOG2];
      ok_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      meas_q <= '0;
      ok_q   <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      meas_q <= meas_d;
      ok_q   <= ok_d;
    end
  end

  assign meas    = meas_q;
  assign meas_ok = ok_q;

  AST_MEAS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !win_last |=> $stable(meas_q)); // R7

  AST_MEAS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> ok_q); // R6

endmodule

// File: rtl/bpc_level_map.sv
module bpc_level_map
  import bpc_pkg::*;
(
  input  logic [7:0] smp_data,
  input  logic [7:0] porch,
  input  logic [7:0] target,
  input  logic [4:0] tip_code,
  input  logic       clamp_en,
  input  logic       hs_mark,
  output logic [7:0] result
);

  logic signed [9:0] shifted;
  logic [7:0]        sat;

  always_comb begin
    shifted = $signed({2'b00, smp_data}) - $signed({2'b00, porch})
            + $signed({2'b00, target});
    if (shifted[9]) begin
      sat = 8'h00;
    end else if (shifted[8]) begin
      sat = 8'hFF;
    end else begin
      sat = shifted[7:0];
    end

    if (!clamp_en) begin
      result = smp_data;
    end else if (hs_mark && (sat < target)) begin
      result = {3'b000, tip_code};
    end else begin
      result = sat;
    end
  end

endmodule

// File: rtl/bpc_clamp.sv
module bpc_clamp
  import bpc_pkg::*;
#(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned OFS_W    = 8,
  parameter int unsigned AVG_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [7:0]       smp_data,
  input  logic             hs_mark,
  input  logic             pal_sel,
  input  logic             clamp_en,
  input  logic [3:0]       tip_val,
  input  logic [OFS_W-1:0] porch_ofs,
  output logic [7:0]       out_data,
  output logic             out_vld,
  output logic [7:0]       blank_lvl
);

  logic       win_hit, win_first, win_last;
  logic [7:0] meas, target, porch_eff, mapped;
  logic       meas_ok;
  logic [4:0] tip_code;
  logic [7:0] out_q, out_d;
  logic       vld_q, vld_d;

  bpc_line_timer #(
    .CNT_W    (CNT_W),
    .OFS_W    (OFS_W),
    .AVG_LOG2 (AVG_LOG2)
  ) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .hs_mark   (hs_mark),
    .porch_ofs (porch_ofs),
    .win_hit   (win_hit),
    .win_first (win_first),
    .win_last  (win_last)
  );

  bpc_porch_avg #(
    .PIX_W    (PIX_W),
    .AVG_LOG2 (AVG_LOG2)
  ) i_avg (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_data  (smp_data),
    .win_hit   (win_hit),
    .win_first (win_first),
    .win_last  (win_last),
    .meas      (meas),
    .meas_ok   (meas_ok)
  );

  // Until a porch has been measured the target itself stands in for it.
  always_comb begin
    target    = blank_target(pal_sel);
    tip_code  = sync_tip_code(pal_sel, tip_val);
    porch_eff = meas_ok ? meas : target;
  end

  bpc_level_map i_map (
    .smp_data (smp_data),
    .porch    (porch_eff),
    .target   (target),
    .tip_code (tip_code),
    .clamp_en (clamp_en),
    .hs_mark  (hs_mark),
    .result   (mapped)
  );

  always_comb begin
    vld_d = smp_vld;
    out_d = smp_vld ? mapped : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      out_q <= out_d;
      vld_q <= vld_d;
    end
  end

  assign out_data  = out_q;
  assign out_vld   = vld_q;
  assign blank_lvl = porch_eff;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> (!out_vld && $stable(out_data))); // R10

  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !clamp_en) |=> (out_data == $past(smp_data))); // R5

  AST_SYNC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && clamp_en && hs_mark) |=>
      ((out_data >= $past(target)) || (out_data == {3'b000, $past(tip_code)}))); // R4

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> out_vld); // R2

endmodule

// File: tb/test_bpc_clamp.sv
module test_bpc_clamp;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_vld;
  logic [7:0] smp_data;
  logic       hs_mark;
  logic       pal_sel;
  logic       clamp_en;
  logic [3:0] tip_val;
  logic [7:0] porch_ofs;
  logic [7:0] out_data;
  logic       out_vld;
  logic [7:0] blank_lvl;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bpc_clamp i_bpc_clamp (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .smp_data  (smp_data),
    .hs_mark   (hs_mark),
    .pal_sel   (pal_sel),
    .clamp_en  (clamp_en),
    .tip_val   (tip_val),
    .porch_ofs (porch_ofs),
    .out_data  (out_data),
    .out_vld   (out_vld),
    .blank_lvl (blank_lvl)
  );

  // {pal, hs, sample, expected, requirement}; porch measured at 0x50.
  localparam logic [21:0] VEC [0:13] = '{
    {1'b0, 1'b0, 8'h50, 8'h3C, 4'd2},  // R2 blanking lands on 0x3C
    {1'b0, 1'b0, 8'h80, 8'h6C, 4'd2},  // R2
    {1'b0, 1'b0, 8'hFF, 8'hEB, 4'd2},  // R2
    {1'b0, 1'b0, 8'h20, 8'h0C, 4'd2},  // R2 low outside sync kept
    {1'b0, 1'b0, 8'h05, 8'h00, 4'd3},  // R3 floor
    {1'b0, 1'b1, 8'h20, 8'h03, 4'd4},  // R4 tip NTSC
    {1'b0, 1'b1, 8'h60, 8'h4C, 4'd4},  // R4 above target kept
    {1'b0, 1'b1, 8'h50, 8'h3C, 4'd4},  // R4 equal to target kept
    {1'b1, 1'b0, 8'h50, 8'h40, 4'd2},  // R2 blanking lands on 0x40
    {1'b1, 1'b0, 8'hF8, 8'hE8, 4'd2},  // R2
    {1'b1, 1'b1, 8'h10, 8'h07, 4'd4},  // R4 tip PAL
    {1'b1, 1'b1, 8'h3F, 8'h07, 4'd4},  // R4
    {1'b1, 1'b0, 8'h00, 8'h00, 4'd3},  // R3 floor
    {1'b1, 1'b0, 8'h13, 8'h03, 4'd2}   // R2
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Present one sample at the falling edge; return at the next falling edge.
  task automatic push(input logic [7:0] d, input logic hs);
    smp_vld  = 1'b1;
    smp_data = d;
    hs_mark  = hs;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n     = 1'b0;
    smp_vld   = 1'b0;
    smp_data  = 8'h00;
    hs_mark   = 1'b0;
    pal_sel   = 1'b0;
    clamp_en  = 1'b1;
    tip_val   = 4'd3;
    porch_ofs = 8'd4;
    repeat (3) @(negedge clk);
    check("R1 out_data", out_data, 8'h00);
    check("R1 out_vld", {7'd0, out_vld}, 8'h00);
    check("R1 ntsc blank", blank_lvl, 8'h3C);
    pal_sel = 1'b1;
    #1 check("R1 pal blank", blank_lvl, 8'h40);
    pal_sel = 1'b0;
    rst_n   = 1'b1;
    @(negedge clk);
    check("R1 after release", out_data, 8'h00);

    // Line 1 (NTSC): porch window at indexes 4..19.
    push(8'h10, 1'b1); check("R4 R8 tip before measure", out_data, 8'h03);
    check("R2 out_vld", {7'd0, out_vld}, 8'h01);
    push(8'h10, 1'b1); check("R4", out_data, 8'h03);
    push(8'h50, 1'b0); check("R8 unshifted", out_data, 8'h50);
    push(8'h50, 1'b0);
    for (int i = 4; i < 19; i++) push(8'h50, 1'b0);
    check("R6 not before 16th", blank_lvl, 8'h3C);
    push(8'h5F, 1'b0); check("R6 old porch on 16th", out_data, 8'h5F);
    check("R6 floor average", blank_lvl, 8'h50);
    for (int i = 0; i < 5; i++) push(8'h90, 1'b0);
    check("R7 once per line", blank_lvl, 8'h50);
    check("R2 shifted", out_data, 8'h7C);

    // Idle cycle leaves output untouched.
    smp_vld = 1'b0;
    smp_data = 8'hAA;
    @(negedge clk);
    check("R10 out_vld low", {7'd0, out_vld}, 8'h00);
    check("R10 data held", out_data, 8'h7C);

    porch_ofs = 8'd200;
    for (int v = 0; v < 14; v++) begin
      pal_sel = VEC[v][21];
      push(VEC[v][19:12], VEC[v][20]);
      check($sformatf("R%0d vec %0d", VEC[v][3:0], v), out_data, VEC[v][11:4]);
    end
    check("R9 report under pal", blank_lvl, 8'h50);

    // Changed tip value, NTSC.
    pal_sel = 1'b0;
    tip_val = 4'd9;
    push(8'h20, 1'b1); check("R4 tip value 9", out_data, 8'h09);
    tip_val = 4'd3;

    // Clamp disabled: raw pass-through.
    clamp_en = 1'b0;
    push(8'h10, 1'b1); check("R5 raw in sync", out_data, 8'h10);
    push(8'hF0, 1'b0); check("R5 raw", out_data, 8'hF0);
    clamp_en = 1'b1;

    // Line 2 (PAL): porch settles at 0x20.
    pal_sel   = 1'b1;
    porch_ofs = 8'd4;
    push(8'h10, 1'b1);
    for (int i = 1; i < 20; i++) push(8'h20, 1'b0);
    check("R6 second line", blank_lvl, 8'h20);
    porch_ofs = 8'd200;
    push(8'hF0, 1'b0); check("R3 ceiling", out_data, 8'hFF);
    push(8'hDF, 1'b0); check("R3 exact top", out_data, 8'hFF);
    push(8'hDE, 1'b0); check("R3 below top", out_data, 8'hFE);
    push(8'h20, 1'b0); check("R2 pal blanking", out_data, 8'h40);

    // Reset again: measurement dropped.
    smp_vld = 1'b0;
    rst_n   = 1'b0;
    #1;
    check("R1 reset clears report", blank_lvl, 8'h40);
    check("R1 reset clears data", out_data, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end

endmodule